// File: doc/BRIEF.md
# Vectored interrupt request manager

This block collects up to 128 level-sensitive request lines and presents them to a processor as two prioritised interrupt outputs: a normal interrupt (IRQ) and a fast interrupt (FIQ). Software controls which channels can interrupt through enable masks. Each enable bit is changed only by a write-one-to-set bank or a write-one-to-clear bank, so one channel can be turned on or off without a read-modify-write sequence.

A per-channel route bank sends each channel either to the IRQ side or to the FIQ side. Each side has an index register that reports the winning channel number plus one. A value of zero means that nothing is pending, so an interrupt handler that finds zero can treat the entry as a phantom.

A small control register holds two 4-bit key fields. When both keys hold the required pattern, an output tells the surrounding memory logic to stop correcting single-bit errors. All access goes through a plain 32-bit read/write register port, and reads return their data in the same cycle.

Top module: `irq_vector_mgr`

## Requirements
- R1: After synchronous reset, all enable and route bits are 0 and both key fields are 0. As a result, both index registers read 0, `irq_out`, `fiq_out` and `ecc_corr_off` are low, and the enable bank reads 0.
- R2: Writing to byte offset 0x30 + 4k sets enable bit n for every 1 in bit n%32 of the data, where k = n/32. Zero data bits leave the matching enables unchanged. The new mask is visible from the cycle after the write.
- R3: Writing to byte offset 0x40 + 4k clears enable bit n for every 1 in bit n%32 of the data, where k = n/32. Zero data bits leave the matching enables unchanged.
- R4: Reading offset 0x30 + 4k or offset 0x40 + 4k returns the current 32 enable bits of word k. Bit i of that word is channel 32k+i.
- R5: The IRQ index at offset 0x00 reads 0 when no channel is pending, enabled and IRQ-routed. Otherwise it reads the lowest such channel number plus one, so channel 0 reads 1 and channel 127 reads 128.
- R6: The route bank at offset 0x50 + 4k is written and read as plain data. A 1 in a route bit sends that channel to the FIQ side. The FIQ index at offset 0x04 uses the same plus-one, lowest-first encoding over FIQ-routed channels only.
- R7: `irq_out` is high exactly while the IRQ index is nonzero, and `fiq_out` is high exactly while the FIQ index is nonzero. The index registers follow `req_in` in the same cycle.
- R8: The key register at offset 0x1F0 stores data bits 3:0 and 19:16 and reads them back in the same positions, with all other bits 0. `ecc_corr_off` is high exactly when bits 3:0 hold 0xA and bits 19:16 hold 0x5.
- R9: Reads of unmapped offsets return 0. Writes to the index registers or to unmapped offsets change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_in | input | NUM_CH | Level request per channel |
| bus_addr | input | AW | Byte address of the register access |
| bus_wr | input | 1 | Write strobe for the current address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, same cycle |
| irq_out | output | 1 | Normal interrupt request |
| fiq_out | output | 1 | Fast interrupt request |
| ecc_corr_off | output | 1 | Single-bit correction disabled |

## Verification
The hardest case to reach is a channel that is pending and enabled but routed to the FIQ side. It must vanish from the IRQ index and appear in the FIQ index, while a lower channel on the IRQ side still wins there. The stimulus first leaves the top channel, 127, as the only enabled IRQ candidate and checks that the index reads 128. It then moves channel 127 to the FIQ side and re-enables channel 40, so that each side reports a different winner at the same time. Partial write patterns, such as zero data and writes to the index registers, confirm that only set bits take effect.

// File: rtl/ivm_pkg.sv
package ivm_pkg;
    localparam int REG_W       = 32;
    localparam int BANK_SLOTS  = 4;
    localparam int OFF_IRQ_IDX = 'h000;
    localparam int OFF_FIQ_IDX = 'h004;
    localparam int OFF_EN_SET  = 'h030;
    localparam int OFF_EN_CLR  = 'h040;
    localparam int OFF_ROUTE   = 'h050;
    localparam int OFF_KEY     = 'h1F0;
    localparam logic [3:0] KEY_LO = 4'hA;
    localparam logic [3:0] KEY_HI = 4'h5;

    typedef enum logic [2:0] {
        SP_NONE, SP_IRQ_IDX, SP_FIQ_IDX, SP_EN_SET, SP_EN_CLR, SP_ROUTE, SP_KEY
    } space_e;

    typedef struct packed {
        space_e     kind;
        logic [1:0] word;
    } dec_t;

    function automatic logic in_bank(int a, int base, int words);
        return (a >= base) && (a < base + 4 * words) && (a % 4 == 0);
    endfunction

    function automatic dec_t decode(int a, int words);
        dec_t d;
        d.kind = SP_NONE;
        d.word = '0;
        if (a == OFF_IRQ_IDX)                 d.kind = SP_IRQ_IDX;
        else if (a == OFF_FIQ_IDX)            d.kind = SP_FIQ_IDX;
        else if (a == OFF_KEY)                d.kind = SP_KEY;
        else if (in_bank(a, OFF_EN_SET, words)) begin
            d.kind = SP_EN_SET;
            d.word = 2'((a - OFF_EN_SET) / 4);
        end else if (in_bank(a, OFF_EN_CLR, words)) begin
            d.kind = SP_EN_CLR;
            d.word = 2'((a - OFF_EN_CLR) / 4);
        end else if (in_bank(a, OFF_ROUTE, words)) begin
            d.kind = SP_ROUTE;
            d.word = 2'((a - OFF_ROUTE) / 4);
        end
        return d;
    endfunction
endpackage

// File: rtl/ivm_mask_bank.sv
module ivm_mask_bank #(
    parameter int WORDS = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        set_we,
    input  logic        clr_we,
    input  logic        route_we,
    input  logic [1:0]  word_sel,
    input  logic [31:0] wdata,
    output logic [31:0] en_w    [WORDS],
    output logic [31:0] route_w [WORDS]
);
    for (genvar k = 0; k < WORDS; k++) begin : g_word
        logic hit;
        assign hit = (int'(word_sel) == k);

        always_ff @(posedge clk) begin
            if (rst) begin
                en_w[k]    <= '0;
                route_w[k] <= '0;
            end else begin
                if (hit && set_we)        en_w[k] <= en_w[k] | wdata;
                else if (hit && clr_we)   en_w[k] <= en_w[k] & ~wdata;
                if (hit && route_we)      route_w[k] <= wdata;
            end
        end
    end
endmodule

// File: rtl/ivm_prio_enc.sv
module ivm_prio_enc #(
    parameter int N  = 128,
    parameter int IW = 8
) (
    input  logic [N-1:0]  req,
    output logic [IW-1:0] code,
    output logic          any
);
    always_comb begin
        code = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) code = IW'(i + 1);
        end
    end
    assign any = |req;
endmodule

// File: rtl/ivm_key_ctl.sv
module ivm_key_ctl
    import ivm_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        we,
    input  logic [31:0] wdata,
    output logic [31:0] rdata,
    output logic        corr_off
);
    logic [3:0] key_lo, key_hi;

    always_ff @(posedge clk) begin
        if (rst) begin
            key_lo <= '0;
            key_hi <= '0;
        end else if (we) begin
            key_lo <= wdata[3:0];
            key_hi <= wdata[19:16];
        end
    end

    assign rdata    = {12'b0, key_hi, 12'b0, key_lo};
    assign corr_off = (key_lo == KEY_LO) && (key_hi == KEY_HI);
endmodule

// File: rtl/irq_vector_mgr.sv
module irq_vector_mgr
    import ivm_pkg::*;
#(
    parameter int NUM_CH = 128,
    parameter int AW     = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] req_in,
    input  logic [AW-1:0]     bus_addr,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq_out,
    output logic              fiq_out,
    output logic              ecc_corr_off
);
    localparam int WORDS = NUM_CH / REG_W;
    localparam int IW    = $clog2(NUM_CH + 1);

    dec_t        dec;
    logic [31:0] en_w    [WORDS];
    logic [31:0] route_w [WORDS];
    logic [NUM_CH-1:0] en_flat, route_flat;
    logic [IW-1:0] irq_code, fiq_code;
    logic [31:0]   key_rdata;

    assign dec = decode(int'(bus_addr), WORDS);

    ivm_mask_bank #(.WORDS(WORDS)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .set_we  (bus_wr && dec.kind == SP_EN_SET),
        .clr_we  (bus_wr && dec.kind == SP_EN_CLR),
        .route_we(bus_wr && dec.kind == SP_ROUTE),
        .word_sel(dec.word),
        .wdata   (bus_wdata),
        .en_w    (en_w),
        .route_w (route_w)
    );

    for (genvar k = 0; k < WORDS; k++) begin : g_flat
        assign en_flat[k*REG_W +: REG_W]    = en_w[k];
        assign route_flat[k*REG_W +: REG_W] = route_w[k];
    end

    ivm_prio_enc #(.N(NUM_CH), .IW(IW)) u_irq_enc (
        .req (req_in & en_flat & ~route_flat),
        .code(irq_code),
        .any (irq_out)
    );

    ivm_prio_enc #(.N(NUM_CH), .IW(IW)) u_fiq_enc (
        .req (req_in & en_flat & route_flat),
        .code(fiq_code),
        .any (fiq_out)
    );

    ivm_key_ctl u_key (
        .clk     (clk),
        .rst     (rst),
        .we      (bus_wr && dec.kind == SP_KEY),
        .wdata   (bus_wdata),
        .rdata   (key_rdata),
        .corr_off(ecc_corr_off)
    );

    always_comb begin
        unique case (dec.kind)
            SP_IRQ_IDX:          bus_rdata = 32'(irq_code);
            SP_FIQ_IDX:          bus_rdata = 32'(fiq_code);
            SP_EN_SET, SP_EN_CLR: bus_rdata = en_w[dec.word];
            SP_ROUTE:            bus_rdata = route_w[dec.word];
            SP_KEY:              bus_rdata = key_rdata;
            default:             bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/ivm_checker.sv
module ivm_checker #(
    parameter int NUM_CH = 128,
    parameter int AW     = 12
) (
    input logic              clk,
    input logic              rst,
    input logic [NUM_CH-1:0] req_in,
    input logic [AW-1:0]     bus_addr,
    input logic              bus_wr,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic [NUM_CH-1:0] en_flat,
    input logic [NUM_CH-1:0] route_flat,
    input logic              irq_out,
    input logic              fiq_out,
    input logic              ecc_corr_off
);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        $past(rst) |-> (en_flat == '0) && (route_flat == '0));

    // R2
    set_word0_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == AW'('h30)) |=>
            en_flat[31:0] == ($past(en_flat[31:0]) | $past(bus_wdata)));

    // R3
    clr_word0_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == AW'('h40)) |=>
            en_flat[31:0] == ($past(en_flat[31:0]) & ~$past(bus_wdata)));

    // R9
    no_write_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !bus_wr |=> $stable(en_flat) && $stable(route_flat));

    // R7
    irq_source_chk: assert property (@(posedge clk) disable iff (rst)
        irq_out |-> |(req_in & en_flat & ~route_flat));

    // R7
    fiq_source_chk: assert property (@(posedge clk) disable iff (rst)
        fiq_out |-> |(req_in & en_flat & route_flat));

    // R5
    idle_index_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == AW'('h0) && !irq_out) |-> bus_rdata == '0);

    // R8
    key_match_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == AW'('h1F0) && ecc_corr_off) |->
            (bus_rdata[3:0] == 4'hA) && (bus_rdata[19:16] == 4'h5));
endmodule

bind irq_vector_mgr ivm_checker #(.NUM_CH(NUM_CH), .AW(AW)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .req_in      (req_in),
    .bus_addr    (bus_addr),
    .bus_wr      (bus_wr),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .en_flat     (en_flat),
    .route_flat  (route_flat),
    .irq_out     (irq_out),
    .fiq_out     (fiq_out),
    .ecc_corr_off(ecc_corr_off)
);

// File: tb/irq_vector_mgr_bench.sv
`timescale 1ns/1ps
module irq_vector_mgr_bench;
    localparam int NUM_CH = 128;
    localparam int AW     = 12;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [NUM_CH-1:0] req_in = '0;
    logic [AW-1:0]     bus_addr = '0;
    logic              bus_wr = 1'b0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              irq_out, fiq_out, ecc_corr_off;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    logic [34:0] exp_q [$];
    string       tag_q [$];

    always #2.5 clk = ~clk;

    irq_vector_mgr #(.NUM_CH(NUM_CH), .AW(AW)) u_irq_vector_mgr (
        .clk(clk), .rst(rst), .req_in(req_in), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_out(irq_out), .fiq_out(fiq_out), .ecc_corr_off(ecc_corr_off)
    );

    // monitor: pops expected items and compares away from the active edge
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            logic [34:0] e;
            string       t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if ({bus_rdata, irq_out, fiq_out, ecc_corr_off} !== e) begin
                failures++;
                $display("FAIL %s: actual rdata=%08h irq=%0b fiq=%0b off=%0b expected rdata=%08h irq=%0b fiq=%0b off=%0b",
                         t, bus_rdata, irq_out, fiq_out, ecc_corr_off,
                         e[34:3], e[2], e[1], e[0]);
            end
        end
    end

    task automatic wr(input int a, input logic [31:0] d);
        @(posedge clk); #1;
        bus_addr  = AW'(a);
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(posedge clk); #1;
        bus_wr    = 1'b0;
    endtask

    // driver: pushes the expected item, then presents the read address
    task automatic rd(input int a, input logic [31:0] e, input logic ei,
                      input logic ef, input logic eo, input string t);
        @(posedge clk); #1;
        bus_wr   = 1'b0;
        bus_addr = AW'(a);
        exp_q.push_back({e, ei, ef, eo});
        tag_q.push_back(t);
    endtask

    initial begin
        #100000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        rd('h000, 0, 0, 0, 0, "R1 irq index");
        rd('h004, 0, 0, 0, 0, "R1 fiq index");
        rd('h030, 0, 0, 0, 0, "R1 enable word0");
        rd('h1F0, 0, 0, 0, 0, "R1 key reg");

        @(posedge clk); #1;
        req_in = '0;
        req_in[5] = 1'b1; req_in[40] = 1'b1; req_in[127] = 1'b1;
        rd('h000, 0, 0, 0, 0, "R5 pending but disabled");

        wr('h034, 32'h0000_0100);
        rd('h034, 32'h0000_0100, 1, 0, 0, "R2 set ch40");
        rd('h044, 32'h0000_0100, 1, 0, 0, "R4 clear bank read");
        rd('h000, 41, 1, 0, 0, "R5 ch40 index");

        wr('h030, 32'h0000_0060);
        rd('h030, 32'h0000_0060, 1, 0, 0, "R2 set ch5 ch6");
        rd('h000, 6, 1, 0, 0, "R5 lowest wins");

        wr('h030, 32'h0);
        rd('h030, 32'h0000_0060, 1, 0, 0, "R2 zero data no change");

        wr('h040, 32'h0000_0020);
        rd('h030, 32'h0000_0040, 1, 0, 0, "R3 clear ch5");
        rd('h000, 41, 1, 0, 0, "R3 index after clear");

        wr('h03C, 32'h8000_0000);
        rd('h04C, 32'h8000_0000, 1, 0, 0, "R4 word3 via clear bank");

        wr('h044, 32'h0000_0100);
        rd('h000, 128, 1, 0, 0, "R5 top channel 127");

        wr('h05C, 32'h8000_0000);
        rd('h000, 0, 0, 1, 0, "R6 ch127 leaves irq side");
        rd('h004, 128, 0, 1, 0, "R6 fiq index");
        rd('h05C, 32'h8000_0000, 0, 1, 0, "R6 route readback");

        wr('h034, 32'h0000_0100);
        rd('h000, 41, 1, 1, 0, "R7 both outputs high");

        @(posedge clk); #1 req_in = '0;
        rd('h004, 0, 0, 0, 0, "R7 outputs drop with requests");

        @(posedge clk); #1 req_in[0] = 1'b1;
        wr('h030, 32'h0000_0001);
        rd('h000, 1, 1, 0, 0, "R5 channel 0 reads 1");

        wr('h000, 32'h0000_FFFF);
        wr('h2A0, 32'hFFFF_FFFF);
        rd('h000, 1, 1, 0, 0, "R9 index write ignored");
        rd('h020, 0, 1, 0, 0, "R9 unmapped read");
        rd('h2A0, 0, 1, 0, 0, "R9 unmapped high read");
        rd('h030, 32'h0000_0041, 1, 0, 0, "R9 mask untouched");

        wr('h1F0, 32'h000A_0005);
        rd('h1F0, 32'h000A_0005, 1, 0, 0, "R8 swapped keys");
        wr('h1F0, 32'hFFF5_FFFA);
        rd('h1F0, 32'h0005_000A, 1, 0, 1, "R8 keys disable correction");

        @(posedge clk);
        @(posedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule